// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Sequencer

This block runs the low-power entry and exit sequence of a processor subsystem. When the core reports that it has executed its idle instruction, the block samples three control bits from a power control register: power-down, stop-all and stop-core-clock. From these it picks one of four sleep modes. It then drops the enables for the core clock, the peripheral clock and the PLL as that mode requires, and holds the core halted.

Each mode has its own wake source. The light modes wake on an interrupt. Peripheral power-down wakes on a synchronous wake-up event. Full power-down wakes on an asynchronous wake-up pin, which the block synchronizes before use. When a wake is accepted, the block restores the clock enables and lets a mode-dependent latency run out. It then gives a one-cycle resume pulse and releases the core. A pipeline-valid output tells the core whether its instruction pipeline survived the sleep.

The clock gating cells, the PLL and the interrupt controller sit outside this block. The block runs on an always-on clock and drives only enable levels.

Top module: `lpm_clk_seq`

## Requirements
- R1: After reset the block is in the run state: core_clk_en, periph_clk_en and pll_en are 1, core_halted is 0, pipe_valid is 1 and resume_pulse is 0.
- R2: On idle entry the mode is decoded by priority and shown on mode_active. ctl_pdown=1 gives full power-down (3). Otherwise ctl_stopall=1 gives core+peripheral power-down (2). Otherwise ctl_stopck=1 gives core power-down (1). With all three bits at 0 the mode is plain idle (0).
- R3: In plain idle, all three enables stay 1, core_halted is 1 and pipe_valid stays 1. An irq sampled at a clock edge starts the wake, and resume_pulse is high in the 2nd cycle after that edge.
- R4: In core power-down, core_clk_en is 0 while periph_clk_en and pll_en are 1, and pipe_valid stays 1. It wakes on irq, with the same 2-cycle latency as R3.
- R5: In core+peripheral power-down, core_clk_en and periph_clk_en are 0, pll_en is 1 and pipe_valid is 0. A wake_evt sampled at an edge starts the wake, and resume_pulse is high in the 5th cycle after that edge.
- R6: In full power-down, all three enables are 0 and pipe_valid is 0. A high on wake_async passes through a 2-stage synchronizer, and then pll_en rises while core_clk_en and periph_clk_en stay 0. The block stays in that state until pll_lock is sampled high. resume_pulse is high in the 5th cycle after that edge.
- R7: Wake inputs that do not belong to the current mode are ignored. An irq does not wake core+peripheral power-down, and wake_evt does not wake plain idle or core power-down.
- R8: During the wake countdown all three enables are 1 and core_halted stays 1. resume_pulse lasts exactly one cycle. In the next cycle core_halted is 0 and pipe_valid is 1.
- R9: If idle_exec and irq are high in the same cycle, the entry is cancelled. The block stays in the run state with core_halted 0 and all enables 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_exec | input | 1 | Core has executed the idle instruction (one-cycle pulse) |
| ctl_pdown | input | 1 | Power-down control bit |
| ctl_stopck | input | 1 | Stop-core-clock control bit |
| ctl_stopall | input | 1 | Stop-all control bit |
| irq | input | 1 | Interrupt request, wakes the light modes |
| wake_evt | input | 1 | Synchronous wake-up event for core+peripheral power-down |
| wake_async | input | 1 | Asynchronous wake-up for full power-down |
| pll_lock | input | 1 | PLL reports lock |
| core_clk_en | output | 1 | Enable for the core clock gate |
| periph_clk_en | output | 1 | Enable for the peripheral clock gate |
| pll_en | output | 1 | PLL run enable |
| core_halted | output | 1 | Core must not issue instructions |
| pipe_valid | output | 1 | Core pipeline contents are still valid |
| resume_pulse | output | 1 | One-cycle pulse when the wake latency ends |
| mode_active | output | 2 | Mode latched at the last idle entry |

## Verification
The bench enters each mode with control bit patterns that overlap on purpose, for example pdown with stopall set, so a decoder with the priority reversed would gate the wrong clocks. It counts the cycles from the sampled wake to resume_pulse. A counter loaded off by one, or a mode given the wrong latency, shows up as a pulse one cycle early or late. In full power-down it holds pll_lock low for several cycles, which catches a design that releases the clocks before lock. It also drives the wrong wake source in each mode and raises irq in the same cycle as idle_exec, which exposes a design that wakes on any input or enters sleep despite a pending interrupt.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        LPM_IDLE        = 2'd0,
        LPM_CORE        = 2'd1,
        LPM_CORE_PERIPH = 2'd2,
        LPM_ALL         = 2'd3
    } lpm_mode_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_PLL_WAIT,
        ST_WAKE
    } lpm_state_e;

    typedef struct packed {
        logic core;
        logic periph;
        logic pll;
    } clk_en_t;

    // Priority: power-down over stop-all over stop-core-clock.
    function automatic lpm_mode_e decode_mode(input logic pdown,
                                              input logic stopall,
                                              input logic stopck);
        if (pdown)
            return LPM_ALL;
        else if (stopall)
            return LPM_CORE_PERIPH;
        else if (stopck)
            return LPM_CORE;
        else
            return LPM_IDLE;
    endfunction

    function automatic logic keeps_pipeline(input lpm_mode_e m);
        return (m == LPM_IDLE) || (m == LPM_CORE);
    endfunction

    function automatic clk_en_t sleep_gates(input lpm_mode_e m);
        clk_en_t g;
        g.core   = (m == LPM_IDLE);
        g.periph = (m == LPM_IDLE) || (m == LPM_CORE);
        g.pll    = (m != LPM_ALL);
        return g;
    endfunction

endpackage

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
    import lpm_pkg::*;
(
    input  logic      pdown,
    input  logic      stopall,
    input  logic      stopck,
    output lpm_mode_e mode,
    output logic      drops_pipe
);
    always_comb begin
        mode       = decode_mode(pdown, stopall, stopck);
        drops_pipe = !keeps_pipeline(mode);
    end
endmodule

// File: rtl/lpm_sync.sv
module lpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R8: a loaded latency is held for the next cycle before counting.
    assert_load_taken_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/lpm_clk_seq.sv
module lpm_clk_seq
    import lpm_pkg::*;
#(
    parameter int SHORT_LAT   = 2,
    parameter int LONG_LAT    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       idle_exec,
    input  logic       ctl_pdown,
    input  logic       ctl_stopck,
    input  logic       ctl_stopall,
    input  logic       irq,
    input  logic       wake_evt,
    input  logic       wake_async,
    input  logic       pll_lock,
    output logic       core_clk_en,
    output logic       periph_clk_en,
    output logic       pll_en,
    output logic       core_halted,
    output logic       pipe_valid,
    output logic       resume_pulse,
    output logic [1:0] mode_active
);
    localparam int MAXLAT = (LONG_LAT > SHORT_LAT) ? LONG_LAT : SHORT_LAT;
    localparam int CW     = $clog2(MAXLAT + 1);

    lpm_state_e state_q;
    lpm_mode_e  mode_q;
    lpm_mode_e  mode_dec;
    logic       drops_pipe;
    logic       wake_sync;
    logic       enter;
    logic       wake_hit;
    logic       timer_load;
    logic [CW-1:0] timer_val;
    logic       timer_expired;
    logic       pipe_q;
    clk_en_t    gates;

    lpm_mode_decode i_decode (
        .pdown      (ctl_pdown),
        .stopall    (ctl_stopall),
        .stopck     (ctl_stopck),
        .mode       (mode_dec),
        .drops_pipe (drops_pipe)
    );

    lpm_sync #(.STAGES(SYNC_STAGES)) i_wake_sync (
        .clk (clk),
        .rst (rst),
        .d   (wake_async),
        .q   (wake_sync)
    );

    // A pending interrupt cancels entry into sleep.
    assign enter = (state_q == ST_RUN) && idle_exec && !irq;

    always_comb begin
        unique case (mode_q)
            LPM_IDLE, LPM_CORE: wake_hit = irq;
            LPM_CORE_PERIPH:    wake_hit = wake_evt;
            default:            wake_hit = wake_sync;
        endcase
    end

    always_comb begin
        timer_load = 1'b0;
        if (state_q == ST_SLEEP && wake_hit && mode_q != LPM_ALL)
            timer_load = 1'b1;
        if (state_q == ST_PLL_WAIT && pll_lock)
            timer_load = 1'b1;
        timer_val = keeps_pipeline(mode_q) ? CW'(SHORT_LAT - 1) : CW'(LONG_LAT - 1);
    end

    lpm_wake_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_expired)
    );

    assign resume_pulse = (state_q == ST_WAKE) && timer_expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            mode_q  <= LPM_IDLE;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (enter) begin
                        state_q <= ST_SLEEP;
                        mode_q  <= mode_dec;
                    end
                end
                ST_SLEEP: begin
                    if (wake_hit)
                        state_q <= (mode_q == LPM_ALL) ? ST_PLL_WAIT : ST_WAKE;
                end
                ST_PLL_WAIT: begin
                    if (pll_lock)
                        state_q <= ST_WAKE;
                end
                default: begin
                    if (timer_expired)
                        state_q <= ST_RUN;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pipe_q <= 1'b1;
        else if (enter && drops_pipe)
            pipe_q <= 1'b0;
        else if (resume_pulse)
            pipe_q <= 1'b1;
    end

    always_comb begin
        unique case (state_q)
            ST_SLEEP:    gates = sleep_gates(mode_q);
            ST_PLL_WAIT: gates = '{core: 1'b0, periph: 1'b0, pll: 1'b1};
            default:     gates = '{core: 1'b1, periph: 1'b1, pll: 1'b1};
        endcase
    end

    assign core_clk_en   = gates.core;
    assign periph_clk_en = gates.periph;
    assign pll_en        = gates.pll;
    assign core_halted   = (state_q != ST_RUN);
    assign pipe_valid    = pipe_q;
    assign mode_active   = mode_q;

    // R6: no clock runs while the PLL is stopped.
    assert_pll_off_gates_R6: assert property (@(posedge clk) disable iff (rst)
        !pll_en |-> (!core_clk_en && !periph_clk_en));

    // R8: resume is a single cycle and releases the core next cycle.
    assert_resume_single_R8: assert property (@(posedge clk) disable iff (rst)
        resume_pulse |=> (!resume_pulse && !core_halted && pipe_valid));

    // R9: idle with a simultaneous interrupt keeps the core running.
    assert_cancel_entry_R9: assert property (@(posedge clk) disable iff (rst)
        (!core_halted && idle_exec && irq) |=> !core_halted);

    // R5: pipeline is reported lost while asleep in a dropping mode.
    assert_pipe_dropped_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && !keeps_pipeline(mode_q)) |-> !pipe_valid);

    // R7: no wake from the light modes without an interrupt.
    assert_light_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && keeps_pipeline(mode_q) && !irq) |=> core_halted);
endmodule

// File: tb/test_lpm_clk_seq.sv
module test_lpm_clk_seq;
    logic clk = 1'b0;
    logic rst, idle_exec, ctl_pdown, ctl_stopck, ctl_stopall;
    logic irq, wake_evt, wake_async, pll_lock;
    logic core_clk_en, periph_clk_en, pll_en, core_halted, pipe_valid, resume_pulse;
    logic [1:0] mode_active;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lpm_clk_seq i_lpm_clk_seq (
        .clk(clk), .rst(rst), .idle_exec(idle_exec),
        .ctl_pdown(ctl_pdown), .ctl_stopck(ctl_stopck), .ctl_stopall(ctl_stopall),
        .irq(irq), .wake_evt(wake_evt), .wake_async(wake_async), .pll_lock(pll_lock),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .pll_en(pll_en),
        .core_halted(core_halted), .pipe_valid(pipe_valid),
        .resume_pulse(resume_pulse), .mode_active(mode_active)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_en(input string req, input int c, input int p, input int l);
        chk(req, "core_clk_en", int'(core_clk_en), c);
        chk(req, "periph_clk_en", int'(periph_clk_en), p);
        chk(req, "pll_en", int'(pll_en), l);
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 5000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic enter_mode(input logic pd, input logic sa, input logic sc);
        @(negedge clk);
        ctl_pdown = pd; ctl_stopall = sa; ctl_stopck = sc; idle_exec = 1'b1;
        @(negedge clk);
        idle_exec = 1'b0;
    endtask

    // Called at the negedge right after the wake edge (or lock edge).
    task automatic run_latency(input string req, input int lat);
        for (int i = 0; i < lat; i++) begin
            chk("R8", "countdown enables", int'({core_clk_en, periph_clk_en, pll_en}), 7);
            chk("R8", "halted in countdown", int'(core_halted), 1);
            chk(req, "resume timing", int'(resume_pulse), (i == lat - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk("R8", "released", int'(core_halted), 0);
        chk("R8", "pipe restored", int'(pipe_valid), 1);
        chk("R8", "pulse ends", int'(resume_pulse), 0);
    endtask

    task automatic t_reset;
        chk("R1", "halted", int'(core_halted), 0);
        chk("R1", "pipe_valid", int'(pipe_valid), 1);
        chk("R1", "resume", int'(resume_pulse), 0);
        chk_en("R1", 1, 1, 1);
    endtask

    task automatic t_idle;
        enter_mode(1'b0, 1'b0, 1'b0);
        chk("R2", "mode idle", int'(mode_active), 0);
        chk("R3", "halted", int'(core_halted), 1);
        chk("R3", "pipe kept", int'(pipe_valid), 1);
        chk_en("R3", 1, 1, 1);
        wake_evt = 1'b1;
        repeat (3) @(negedge clk);
        wake_evt = 1'b0;
        chk("R7", "wake_evt ignored in idle", int'(core_halted), 1);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        run_latency("R3", 2);
    endtask

    task automatic t_core;
        enter_mode(1'b0, 1'b0, 1'b1);
        chk("R2", "mode core", int'(mode_active), 1);
        chk_en("R4", 0, 1, 1);
        chk("R4", "pipe kept", int'(pipe_valid), 1);
        wake_evt = 1'b1;
        repeat (3) @(negedge clk);
        wake_evt = 1'b0;
        chk("R7", "wake_evt ignored in core pd", int'(core_halted), 1);
        chk("R7", "core clock still off", int'(core_clk_en), 0);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        run_latency("R4", 2);
    endtask

    task automatic t_core_periph;
        enter_mode(1'b0, 1'b1, 1'b1);
        chk("R2", "stopall over stopck", int'(mode_active), 2);
        chk_en("R5", 0, 0, 1);
        chk("R5", "pipe dropped", int'(pipe_valid), 0);
        irq = 1'b1;
        repeat (3) @(negedge clk);
        irq = 1'b0;
        chk("R7", "irq ignored in core+periph pd", int'(core_halted), 1);
        chk("R7", "periph clock still off", int'(periph_clk_en), 0);
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        run_latency("R5", 5);
    endtask

    task automatic t_all;
        int waited;
        enter_mode(1'b1, 1'b1, 1'b0);
        chk("R2", "pdown over stopall", int'(mode_active), 3);
        chk_en("R6", 0, 0, 0);
        chk("R6", "pipe dropped", int'(pipe_valid), 0);
        wake_async = 1'b1;
        waited = 0;
        while (!pll_en && waited < 10) begin
            @(negedge clk);
            waited++;
        end
        wake_async = 1'b0;
        chk("R6", "sync delay cycles", waited, 3);
        chk_en("R6", 0, 0, 1);
        repeat (4) @(negedge clk);
        chk_en("R6", 0, 0, 1);
        chk("R6", "waits for lock", int'(core_halted), 1);
        pll_lock = 1'b1;
        @(negedge clk);
        run_latency("R6", 5);
        pll_lock = 1'b0;
    endtask

    task automatic t_cancel;
        @(negedge clk);
        ctl_pdown = 1'b0; ctl_stopall = 1'b1; ctl_stopck = 1'b0;
        idle_exec = 1'b1; irq = 1'b1;
        @(negedge clk);
        idle_exec = 1'b0; irq = 1'b0;
        chk("R9", "not halted", int'(core_halted), 0);
        chk_en("R9", 1, 1, 1);
        chk("R9", "pipe kept", int'(pipe_valid), 1);
    endtask

    initial begin
        rst = 1'b1; idle_exec = 1'b0; ctl_pdown = 1'b0; ctl_stopck = 1'b0;
        ctl_stopall = 1'b0; irq = 1'b0; wake_evt = 1'b0; wake_async = 1'b0;
        pll_lock = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_core();
        t_core_periph();
        t_all();
        t_cancel();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule